// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a shared packet buffer. The buffer is split into fixed 2 KB pages, and each page is named by a six-bit packet number. With the default 128 KB of buffer there are 64 such numbers, shared freely between the transmit and receive sides. The host sends commands to the block: it can ask for a page for a given byte count, give a page back, queue a packet number for transmission, or clear the transmit or receive queues. The receive path asks for pages on its own request line. A configurable transmit reserve keeps receive traffic from taking the last pages the host will need for sending.

The block holds three FIFOs of packet numbers. The transmit queue feeds the MAC. The completion FIFO and the receive FIFO are read by the host one entry at a time. When a transmit completes, its packet number goes to the completion FIFO. The exception is when automatic release is on and the transmit succeeded: then the page is freed at once and nothing is queued. Three interrupt sources (allocation done, transmit, transmit queue drained) each have a mask bit, and their unmasked OR drives a single interrupt line. The block moves no packet data.

Top module: `pktbuf_page_alloc`

## Requirements
- R1: After reset, all pages are free, all three FIFOs are empty, `int_pend` is 0, `alloc_fail` is 0 and `irq` is 0.
- R2: The command code 1 (allocate) is handled in one clock. If the byte count is at most 2048 and a page is free, the lowest-numbered free packet number appears on `alloc_pnum` after the next edge with `alloc_fail`=0. If the byte count is above 2048, `alloc_fail` is 1 instead. In both cases `int_pend[0]` (allocation done) is set.
- R3: When all 64 pages are in use, an allocate command sets `alloc_fail`=1 and changes no page state.
- R4: The command code 2 (release) frees the page named by `cmd_pnum`. A later allocate can return that number again.
- R5: A receive request is answered one cycle later on `rx_grant_*`. It is granted only if the number of free pages is greater than the outstanding reserve. The outstanding reserve is the reserve in pages (`cfg_reserve` × 256 × M bytes, rounded up to whole pages) minus the pages held by host allocations, and never less than 0. A granted receive takes the lowest free page.
- R6: A receive request made in the same cycle as a host allocate command is refused.
- R7: The command code 3 (enqueue) puts `cmd_pnum` into the transmit queue. The MAC sees the queue head on `txq_pnum` while `txq_valid` is 1, in FIFO order, and advances it with `txq_pop`.
- R8: A transmit completion pushes its packet number into the completion FIFO. The exception is when `cfg_auto_rel`=1 and `tx_done_ok`=1: then the page is freed and nothing is pushed.
- R9: The host reads the completion FIFO and the receive FIFO one number per pop, in arrival order. Each FIFO shows an empty flag, and a pop on an empty FIFO has no effect.
- R10: `int_pend[1]` (transmit) is 1 exactly while the completion FIFO is not empty. `int_pend[2]` (transmit empty) is set when a completion retires the last in-flight packet while the transmit queue is empty. `int_ack` bits 0 and 2 clear their sticky flags.
- R11: `irq` is the OR of `int_pend & int_mask`.
- R12: The command code 4 empties the transmit queue and the completion FIFO but leaves their pages allocated. The command code 5 empties the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Command code (1 alloc, 2 release, 3 enqueue, 4 clear tx, 5 clear rx) |
| cmd_bytes | input | 12 | Byte count for allocate |
| cmd_pnum | input | 6 | Packet number for release and enqueue |
| cfg_reserve | input | 8 | Transmit reserve in 256×M-byte units |
| cfg_auto_rel | input | 1 | Free pages of successful transmits automatically |
| int_mask | input | 3 | Interrupt enables |
| int_ack | input | 3 | Clear strobes for sticky interrupt flags |
| alloc_pnum | output | 6 | Packet number from the last successful allocate |
| alloc_fail | output | 1 | Last allocate failed |
| rx_alloc_req | input | 1 | Receive page request |
| rx_grant_valid | output | 1 | Receive request answered |
| rx_grant_ok | output | 1 | Receive request granted |
| rx_grant_pnum | output | 6 | Granted receive packet number |
| rx_done_valid | input | 1 | Received packet ready for host |
| rx_done_pnum | input | 6 | Its packet number |
| txq_pop | input | 1 | MAC takes queue head |
| txq_valid | output | 1 | Transmit queue not empty |
| txq_pnum | output | 6 | Transmit queue head |
| tx_done_valid | input | 1 | Transmit completed |
| tx_done_ok | input | 1 | Transmit succeeded |
| tx_done_pnum | input | 6 | Completed packet number |
| host_txc_pop | input | 1 | Host reads completion FIFO |
| txc_empty | output | 1 | Completion FIFO empty |
| txc_pnum | output | 6 | Completion FIFO head |
| host_rx_pop | input | 1 | Host reads receive FIFO |
| rxf_empty | output | 1 | Receive FIFO empty |
| rxf_pnum | output | 6 | Receive FIFO head |
| int_pend | output | 3 | Pending sources: bit 0 alloc, bit 1 tx, bit 2 tx empty |
| irq | output | 1 | Combined interrupt |

## Verification
A page bitmap that is wrong in either direction shows up at the next allocate. A page stuck as used is skipped, so a higher packet number comes back. A page left free after it was taken comes back twice. A wrong ownership count moves the receive grant boundary by one page, and the reserve sweep sees that one cycle after the request. FIFO pointer errors show up on the next pop as numbers out of order or as a wrong empty flag. Interrupt faults show on `int_pend` and `irq` one edge after the event that set or acknowledged them.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int NPKT       = 64;
    localparam int PW         = $clog2(NPKT);
    localparam int PAGE_BYTES = 2048;
    localparam int BYTES_W    = 12;
    localparam int RES_W      = 8;
    localparam int RES_MULT   = 8;
    localparam int RES_UNIT   = 256 * RES_MULT;

    typedef logic [PW-1:0] pnum_t;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RELEASE = 3'd2,
        OP_ENQUEUE = 3'd3,
        OP_CLR_TX  = 3'd4,
        OP_CLR_RX  = 3'd5
    } op_e;

    localparam int IB_ALLOC = 0;
    localparam int IB_TX    = 1;
    localparam int IB_TXEMP = 2;
endpackage

// File: rtl/pa_fifo.sv
module pa_fifo #(
    parameter int DEPTH = pa_pkg::NPKT,
    parameter int DW    = pa_pkg::PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= AW'((int'(wp) + 1) % DEPTH);
            if (do_pop)  rp <= AW'((int'(rp) + 1) % DEPTH);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // capacity matches the packet-number space, so a legal flow never overfills (R9)
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        push && !flush |-> !full);
    // a pop on an empty FIFO leaves it empty (R9)
    p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
        pop && empty && !push |=> empty);
endmodule

// File: rtl/pa_page_pool.sv
module pa_page_pool
    import pa_pkg::*;
#(
    parameter int N       = NPKT,
    parameter int PGB     = PAGE_BYTES,
    parameter int BW      = BYTES_W,
    parameter int RW      = RES_W,
    parameter int RUNIT   = RES_UNIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic [BW-1:0] host_bytes,
    input  logic          rx_req,
    input  logic          rel_a_v,
    input  pnum_t         rel_a_pnum,
    input  logic          rel_b_v,
    input  pnum_t         rel_b_pnum,
    input  logic [RW-1:0] res_cfg,
    output logic          host_ok,
    output logic          rx_ok,
    output pnum_t         grant_pnum
);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0] used, own_tx, used_nxt, own_nxt;
    logic         any_free;
    logic [CW-1:0] free_cnt, tx_held;
    logic [31:0]  res_pages, res_left;

    always_comb begin
        grant_pnum = '0;
        any_free   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                grant_pnum = pnum_t'(i);
                any_free   = 1'b1;
            end
        end
    end

    assign free_cnt  = CW'(N - $countones(used));
    assign tx_held   = CW'($countones(used & own_tx));
    assign res_pages = (32'(res_cfg) * 32'(RUNIT) + 32'(PGB - 1)) / 32'(PGB);
    assign res_left  = (res_pages > 32'(tx_held)) ? res_pages - 32'(tx_held) : 32'd0;

    assign host_ok = host_req && any_free && (32'(host_bytes) <= 32'(PGB));
    assign rx_ok   = rx_req && !host_req && (32'(free_cnt) > res_left);

    always_comb begin
        used_nxt = used;
        own_nxt  = own_tx;
        if (rel_a_v) used_nxt[rel_a_pnum] = 1'b0;
        if (rel_b_v) used_nxt[rel_b_pnum] = 1'b0;
        if (host_ok || rx_ok) begin
            used_nxt[grant_pnum] = 1'b1;
            own_nxt[grant_pnum]  = host_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used   <= '0;
            own_tx <= '0;
        end else begin
            used   <= used_nxt;
            own_tx <= own_nxt;
        end
    end

    // a granted page is marked in use on the following cycle (R2)
    p_grant_marks_r2: assert property (@(posedge clk) disable iff (rst)
        (host_ok || rx_ok) |=> used[$past(grant_pnum)]);
    // with every page taken, nothing is granted (R3)
    p_full_refuse_r3: assert property (@(posedge clk) disable iff (rst)
        (free_cnt == '0) |-> !(host_ok || rx_ok));
endmodule

// File: rtl/pa_irq.sv
module pa_irq
    import pa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       alloc_set,
    input  logic       txemp_set,
    input  logic       tx_level,
    input  logic [2:0] ack,
    input  logic [2:0] mask,
    output logic [2:0] pend,
    output logic       irq
);
    logic alloc_f, txemp_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_f <= 1'b0;
            txemp_f <= 1'b0;
        end else begin
            alloc_f <= alloc_set | (alloc_f & ~ack[IB_ALLOC]);
            txemp_f <= txemp_set | (txemp_f & ~ack[IB_TXEMP]);
        end
    end

    assign pend = {txemp_f, tx_level, alloc_f};
    assign irq  = |(pend & mask);

    // an acknowledge without a new event clears the flag (R10)
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        ack[IB_ALLOC] && !alloc_set |=> !pend[IB_ALLOC]);
endmodule

// File: rtl/pktbuf_page_alloc.sv
module pktbuf_page_alloc
    import pa_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [BYTES_W-1:0] cmd_bytes,
    input  logic [PW-1:0]      cmd_pnum,
    input  logic [RES_W-1:0]   cfg_reserve,
    input  logic               cfg_auto_rel,
    input  logic [2:0]         int_mask,
    input  logic [2:0]         int_ack,
    output logic [PW-1:0]      alloc_pnum,
    output logic               alloc_fail,
    input  logic               rx_alloc_req,
    output logic               rx_grant_valid,
    output logic               rx_grant_ok,
    output logic [PW-1:0]      rx_grant_pnum,
    input  logic               rx_done_valid,
    input  logic [PW-1:0]      rx_done_pnum,
    input  logic               txq_pop,
    output logic               txq_valid,
    output logic [PW-1:0]      txq_pnum,
    input  logic               tx_done_valid,
    input  logic               tx_done_ok,
    input  logic [PW-1:0]      tx_done_pnum,
    input  logic               host_txc_pop,
    output logic               txc_empty,
    output logic [PW-1:0]      txc_pnum,
    input  logic               host_rx_pop,
    output logic               rxf_empty,
    output logic [PW-1:0]      rxf_pnum,
    output logic [2:0]         int_pend,
    output logic               irq
);
    localparam int FW = $clog2(NPKT + 1);

    logic  c_alloc, c_rel, c_enq, c_clrtx, c_clrrx;
    logic  host_ok, rx_ok, auto_free, txq_empty, txq_take, txemp_set;
    pnum_t grant;
    logic [FW-1:0] in_flight;

    assign c_alloc = cmd_valid && (cmd_op == OP_ALLOC);
    assign c_rel   = cmd_valid && (cmd_op == OP_RELEASE);
    assign c_enq   = cmd_valid && (cmd_op == OP_ENQUEUE);
    assign c_clrtx = cmd_valid && (cmd_op == OP_CLR_TX);
    assign c_clrrx = cmd_valid && (cmd_op == OP_CLR_RX);

    assign auto_free = tx_done_valid && tx_done_ok && cfg_auto_rel;
    assign txq_valid = !txq_empty;
    assign txq_take  = txq_pop && txq_valid && !c_clrtx;

    pa_page_pool u_pool (
        .clk(clk), .rst(rst),
        .host_req(c_alloc), .host_bytes(cmd_bytes), .rx_req(rx_alloc_req),
        .rel_a_v(c_rel), .rel_a_pnum(cmd_pnum),
        .rel_b_v(auto_free), .rel_b_pnum(tx_done_pnum),
        .res_cfg(cfg_reserve),
        .host_ok(host_ok), .rx_ok(rx_ok), .grant_pnum(grant)
    );

    pa_fifo u_txq (
        .clk(clk), .rst(rst), .flush(c_clrtx),
        .push(c_enq), .din(cmd_pnum), .pop(txq_take),
        .dout(txq_pnum), .empty(txq_empty)
    );

    pa_fifo u_txc (
        .clk(clk), .rst(rst), .flush(c_clrtx),
        .push(tx_done_valid && !auto_free), .din(tx_done_pnum), .pop(host_txc_pop),
        .dout(txc_pnum), .empty(txc_empty)
    );

    pa_fifo u_rxf (
        .clk(clk), .rst(rst), .flush(c_clrrx),
        .push(rx_done_valid), .din(rx_done_pnum), .pop(host_rx_pop),
        .dout(rxf_pnum), .empty(rxf_empty)
    );

    assign txemp_set = tx_done_valid && (in_flight == FW'(1)) && txq_empty
                       && !c_enq && !txq_take;

    pa_irq u_irq (
        .clk(clk), .rst(rst),
        .alloc_set(c_alloc), .txemp_set(txemp_set), .tx_level(!txc_empty),
        .ack(int_ack), .mask(int_mask), .pend(int_pend), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_pnum     <= '0;
            alloc_fail     <= 1'b0;
            rx_grant_valid <= 1'b0;
            rx_grant_ok    <= 1'b0;
            rx_grant_pnum  <= '0;
            in_flight      <= '0;
        end else begin
            if (c_alloc) begin
                alloc_fail <= !host_ok;
                if (host_ok) alloc_pnum <= grant;
            end
            rx_grant_valid <= rx_alloc_req;
            rx_grant_ok    <= rx_ok;
            rx_grant_pnum  <= rx_ok ? grant : '0;
            if (txq_take && !(tx_done_valid && in_flight != '0))
                in_flight <= in_flight + FW'(1);
            else if (!txq_take && tx_done_valid && in_flight != '0)
                in_flight <= in_flight - FW'(1);
        end
    end

    // the drained flag only rises while the transmit queue is empty (R10)
    p_txemp_when_empty_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(int_pend[IB_TXEMP]) |-> !txq_valid);
    // a successful auto-released transmit never lands in the completion FIFO (R8)
    p_autorel_skip_r8: assert property (@(posedge clk) disable iff (rst)
        auto_free && txc_empty && !c_clrtx |=> txc_empty);
endmodule

// File: tb/pktbuf_page_alloc_bench.sv
module pktbuf_page_alloc_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       cmd_valid = 0, cfg_auto_rel = 0, rx_alloc_req = 0, rx_done_valid = 0;
    logic       txq_pop = 0, tx_done_valid = 0, tx_done_ok = 0, host_txc_pop = 0, host_rx_pop = 0;
    logic [2:0] cmd_op = 0, int_mask = 0, int_ack = 0;
    logic [11:0] cmd_bytes = 0;
    logic [5:0] cmd_pnum = 0, rx_done_pnum = 0, tx_done_pnum = 0;
    logic [7:0] cfg_reserve = 0;
    logic [5:0] alloc_pnum, rx_grant_pnum, txq_pnum, txc_pnum, rxf_pnum;
    logic       alloc_fail, rx_grant_valid, rx_grant_ok, txq_valid, txc_empty, rxf_empty, irq;
    logic [2:0] int_pend;

    pktbuf_page_alloc u_pktbuf_page_alloc (.*);

    int total = 0, bad = 0;
    int exp_txc[$];
    int exp_rx[$];

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cmd_valid = 0; rx_alloc_req = 0; rx_done_valid = 0; txq_pop = 0;
        tx_done_valid = 0; host_txc_pop = 0; host_rx_pop = 0; int_ack = 0;
    endtask

    task automatic cmd(input logic [2:0] op, input int bytes, input int pn);
        cmd_valid = 1; cmd_op = op; cmd_bytes = 12'(bytes); cmd_pnum = 6'(pn);
        tick();
    endtask

    task automatic tx_done(input int pn, input logic ok);
        tx_done_valid = 1; tx_done_pnum = 6'(pn); tx_done_ok = ok;
        if (!(ok && cfg_auto_rel)) exp_txc.push_back(pn);
        tick();
    endtask

    task automatic rx_done(input int pn);
        rx_done_valid = 1; rx_done_pnum = 6'(pn);
        exp_rx.push_back(pn);
        tick();
    endtask

    // monitor side of the scoreboard: pops host FIFOs and compares with expectations
    task automatic read_txc(string req);
        int e;
        e = exp_txc.pop_front();
        chk(req, int'(txc_pnum), e);
        chk(req, int'(txc_empty), 0);
        host_txc_pop = 1; tick();
    endtask

    task automatic read_rx(string req);
        int e;
        e = exp_rx.pop_front();
        chk(req, int'(rxf_pnum), e);
        chk(req, int'(rxf_empty), 0);
        host_rx_pop = 1; tick();
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 pend", int'(int_pend), 0);
        chk("R1 fail", int'(alloc_fail), 0);
        chk("R1 txq", int'(txq_valid), 0);
        chk("R1 txc", int'(txc_empty), 1);
        chk("R1 rxf", int'(rxf_empty), 1);
        chk("R1 irq", int'(irq), 0);

        // R2 allocate lowest free
        cmd(3'd1, 100, 0);
        chk("R2 pnum0", int'(alloc_pnum), 0);
        chk("R2 fail", int'(alloc_fail), 0);
        chk("R2 pend", int'(int_pend[0]), 1);
        int_ack = 3'b001; tick();
        chk("R10 ack alloc", int'(int_pend[0]), 0);
        cmd(3'd1, 2048, 0);
        chk("R2 pnum1", int'(alloc_pnum), 1);
        cmd(3'd1, 1, 0);
        chk("R2 pnum2", int'(alloc_pnum), 2);
        cmd(3'd1, 3000, 0);
        chk("R2 oversize", int'(alloc_fail), 1);

        // R4 release and reuse
        cmd(3'd2, 0, 1);
        cmd(3'd1, 64, 0);
        chk("R4 reuse", int'(alloc_pnum), 1);
        chk("R4 fail", int'(alloc_fail), 0);

        // R11 mask
        int_ack = 3'b001; tick();
        cmd(3'd1, 4000, 0);
        chk("R11 unmasked", int'(irq), 0);
        int_mask = 3'b001; #1;
        chk("R11 masked in", int'(irq), 1);
        int_mask = 3'b000; int_ack = 3'b001; tick();

        // R7 transmit queue order
        cmd(3'd3, 0, 0);
        cmd(3'd3, 0, 2);
        chk("R7 valid", int'(txq_valid), 1);
        chk("R7 head0", int'(txq_pnum), 0);
        txq_pop = 1; tick();
        chk("R7 head2", int'(txq_pnum), 2);
        txq_pop = 1; tick();
        chk("R7 drained", int'(txq_valid), 0);

        // R8/R10 completions
        tx_done(0, 1'b0);
        chk("R10 tx level", int'(int_pend[1]), 1);
        chk("R10 no early txemp", int'(int_pend[2]), 0);
        cfg_auto_rel = 1;
        tx_done(2, 1'b1);
        chk("R10 txemp", int'(int_pend[2]), 1);
        read_txc("R9 txc");
        chk("R9 txc empty", int'(txc_empty), 1);
        chk("R10 tx cleared", int'(int_pend[1]), 0);
        int_ack = 3'b100; tick();
        chk("R10 ack txemp", int'(int_pend[2]), 0);
        cfg_auto_rel = 0;
        cmd(3'd1, 10, 0);
        chk("R8 autofreed", int'(alloc_pnum), 2);

        // R5 reserve: used {0,1,2} host-held, 61 free
        cfg_reserve = 8'd8;
        rx_alloc_req = 1; tick();
        chk("R5 grant v", int'(rx_grant_valid), 1);
        chk("R5 grant ok", int'(rx_grant_ok), 1);
        chk("R5 grant pn", int'(rx_grant_pnum), 3);
        cfg_reserve = 8'd63;
        rx_alloc_req = 1; tick();
        chk("R5 refuse", int'(rx_grant_ok), 0);
        cfg_reserve = 8'd62;
        rx_alloc_req = 1; tick();
        chk("R5 edge ok", int'(rx_grant_ok), 1);
        chk("R5 edge pn", int'(rx_grant_pnum), 4);
        cfg_reserve = 8'd0;

        // R6 host wins same cycle
        rx_alloc_req = 1;
        cmd(3'd1, 10, 0);
        chk("R6 rx refused", int'(rx_grant_ok), 0);
        chk("R6 host pn", int'(alloc_pnum), 5);

        // R9 receive FIFO
        rx_done(3);
        rx_done(4);
        read_rx("R9 rx first");
        read_rx("R9 rx second");
        chk("R9 rx empty", int'(rxf_empty), 1);
        host_rx_pop = 1; tick();
        chk("R9 pop empty", int'(rxf_empty), 1);

        // R12 clear transmit side keeps pages
        cmd(3'd3, 0, 5);
        tx_done(0, 1'b0);
        void'(exp_txc.pop_front());
        cmd(3'd4, 0, 0);
        chk("R12 txq clr", int'(txq_valid), 0);
        chk("R12 txc clr", int'(txc_empty), 1);
        cmd(3'd1, 10, 0);
        chk("R12 page kept", int'(alloc_pnum), 6);
        rx_done(3);
        void'(exp_rx.pop_front());
        cmd(3'd5, 0, 0);
        chk("R12 rx clr", int'(rxf_empty), 1);

        // R3 exhaust the pool
        for (int i = 7; i < 64; i++) begin
            cmd(3'd1, 100, 0);
            if (alloc_fail || alloc_pnum != 6'(i)) chk("R3 fill", int'(alloc_pnum), i);
        end
        total++;
        cmd(3'd1, 100, 0);
        chk("R3 full", int'(alloc_fail), 1);
        chk("R3 pnum held", int'(alloc_pnum), 63);
        cmd(3'd2, 0, 40);
        cmd(3'd1, 100, 0);
        chk("R4 after full", int'(alloc_pnum), 40);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule